// File: doc/BRIEF.md
# Pointer-Based Data Address Generator

This block forms data-memory addresses for indirect byte loads and stores. Three 16-bit pointers come from the top six bytes of a 32-entry, 8-bit register file. Each pointer is a pair of registers, and the lower-numbered register of the pair holds the low byte. For each request the block drives the effective address and tells the memory whether the access is a read or a write. When the addressing mode changes the pointer, it also drives a write-back of the new pointer value to the register pair.

The block also owns a stack pointer that grows toward lower addresses. It handles one-byte push and pop, and two-byte push and pop of return addresses. It refuses any stack operation that would move the stack pointer below the end of the I/O register area.

All outputs except the stack pointer are combinational in the request inputs. The register file and the stack pointer take their new values on the clock edge at which the access is issued.

Top module: `ptr_agen`

## Requirements
- R1: `ptr_sel` 0, 1 and 2 pick the pointers built from registers 26/27, 28/29 and 30/31, with the lower register as the low byte. Every write-back names the low register of the pair on `wb_idx` (26, 28 or 30).
- R2: Mode 0 (plain indirect) drives the pointer value as the address and asserts no write-back.
- R3: Mode 1 (post-increment) uses the current pointer as the address and writes back pointer+1 modulo 2^16. A carry from the low byte reaches the high byte in the same cycle.
- R4: Mode 2 (pre-decrement) uses pointer-1 modulo 2^16 as the address and writes back that same value. A borrow from the high byte is taken in the same cycle.
- R5: Mode 3 (displacement) drives the pointer plus the zero-extended 6-bit `disp` (0 to 63), modulo 2^16, and asserts no write-back.
- R6: Mode 4 (byte push) writes at the current stack pointer. The stack pointer reads one less after the next clock edge.
- R7: Mode 5 (byte pop) reads at stack pointer+1. The stack pointer reads one more after the next clock edge.
- R8: Mode 6 (return push) makes a two-byte write (`mem_wide`=1) at stack pointer-1 and moves the stack pointer down by 2. Mode 7 (return pop) makes a two-byte read at stack pointer+1 and moves it up by 2.
- R9: A stack operation whose resulting stack pointer would be below 0x0060 raises `stack_fault`. It then issues no access and leaves the stack pointer unchanged.
- R10: With `req` low, or with `ptr_sel`=3 in modes 0 to 3, there is no access, no write-back and no change to the stack pointer.
- R11: After reset the stack pointer is 0x045F, and no access is issued while `req` is low.
- R12: In modes 0 to 3, `mem_write` follows `store`. Pushes write and pops read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Request strobe |
| ptr_sel | input | 2 | Pointer select (0..2; 3 is unused) |
| mode | input | 3 | Addressing / stack operation |
| disp | input | 6 | Unsigned displacement |
| store | input | 1 | 1 for store in pointer modes |
| ptr_x | input | 16 | Registers 27:26 |
| ptr_y | input | 16 | Registers 29:28 |
| ptr_z | input | 16 | Registers 31:30 |
| mem_valid | output | 1 | Access issued this cycle |
| mem_write | output | 1 | Access is a write |
| mem_wide | output | 1 | Two-byte return-address access |
| mem_addr | output | 16 | Effective address |
| wb_en | output | 1 | Pointer write-back enable |
| wb_idx | output | 5 | Low register index of the pair |
| wb_val | output | 16 | Updated pointer value |
| sp | output | 16 | Stack pointer |
| stack_fault | output | 1 | Stack operation refused |

## Verification
The pointer modes are tried with pointers in the middle of the address range and at the wrap points 0xFFFF and 0x0200. These cases separate a true 16-bit carry or borrow from a step that stays within one byte, and separate a wrapping displacement from one that saturates. The tests run a push/pop sequence of bytes and return addresses in turn, which checks that the step sizes and the write-then-move versus move-then-read ordering are correct. A long run of pushes drives the stack pointer to the floor, where only the operations that would cross it are refused. Requests on the unused pointer select show that neither the register file nor the stack pointer changes.

// File: rtl/ptr_agen.sv
module ptr_agen #(
  parameter int AW          = 16,
  parameter int DW          = 6,
  parameter int BASE_REG    = 26,
  parameter logic [15:0] SP_INIT  = 16'h045F,
  parameter logic [15:0] SP_FLOOR = 16'h0060
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic [1:0]    ptr_sel,
  input  logic [2:0]    mode,
  input  logic [DW-1:0] disp,
  input  logic          store,
  input  logic [AW-1:0] ptr_x,
  input  logic [AW-1:0] ptr_y,
  input  logic [AW-1:0] ptr_z,
  output logic          mem_valid,
  output logic          mem_write,
  output logic          mem_wide,
  output logic [AW-1:0] mem_addr,
  output logic          wb_en,
  output logic [4:0]    wb_idx,
  output logic [AW-1:0] wb_val,
  output logic [AW-1:0] sp,
  output logic          stack_fault
);
  localparam int HB = AW / 2;
  localparam logic [2:0] M_PLAIN = 3'd0, M_POST = 3'd1, M_PRE = 3'd2, M_DISP = 3'd3,
                         M_PUSH = 3'd4, M_POP = 3'd5, M_RPUSH = 3'd6, M_RPOP = 3'd7;

  logic [AW-1:0] ptr, ptr_inc, ptr_dec, sp_next;
  logic          ptr_ok, stk_op;
  logic [HB:0]   lo_inc, lo_dec;

  always_comb begin
    case (ptr_sel)
      2'd0:    ptr = ptr_x;
      2'd1:    ptr = ptr_y;
      default: ptr = ptr_z;
    endcase
  end

  assign lo_inc  = {1'b0, ptr[HB-1:0]} + 1'b1;
  assign lo_dec  = {1'b0, ptr[HB-1:0]} - 1'b1;
  assign ptr_inc = {ptr[AW-1:HB] + lo_inc[HB], lo_inc[HB-1:0]};
  assign ptr_dec = {ptr[AW-1:HB] - lo_dec[HB], lo_dec[HB-1:0]};

  assign stk_op = mode[2];
  assign ptr_ok = !stk_op && (ptr_sel != 2'd3);

  always_comb begin
    case (mode)
      M_PUSH:  sp_next = sp - 16'd1;
      M_POP:   sp_next = sp + 16'd1;
      M_RPUSH: sp_next = sp - 16'd2;
      M_RPOP:  sp_next = sp + 16'd2;
      default: sp_next = sp;
    endcase
  end

  assign stack_fault = req && stk_op && (sp_next < SP_FLOOR);
  assign mem_valid   = req && (ptr_ok || (stk_op && !stack_fault));
  assign mem_wide    = mem_valid && (mode == M_RPUSH || mode == M_RPOP);
  assign mem_write   = mem_valid && (stk_op ? !mode[0] : store);

  always_comb begin
    case (mode)
      M_PRE:   mem_addr = ptr_dec;
      M_DISP:  mem_addr = ptr + {{(AW-DW){1'b0}}, disp};
      M_PUSH:  mem_addr = sp;
      M_RPUSH: mem_addr = sp - 16'd1;
      M_POP,
      M_RPOP:  mem_addr = sp + 16'd1;
      default: mem_addr = ptr;
    endcase
  end

  assign wb_en  = req && ptr_ok && (mode == M_POST || mode == M_PRE);
  assign wb_val = (mode == M_PRE) ? ptr_dec : ptr_inc;
  assign wb_idx = 5'(BASE_REG + 2 * ptr_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              sp <= SP_INIT;
    else if (req && stk_op && !stack_fault)  sp <= sp_next;
  end

  // R6
  push_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req && mode == M_PUSH && !stack_fault |=> sp == $past(sp) - 16'd1);
  // R8
  ret_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req && mode == M_RPUSH && !stack_fault |=> sp == $past(sp) - 16'd2);
  // R9
  fault_noacc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stack_fault |-> !mem_valid && !wb_en);
  // R9
  fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stack_fault |=> $stable(sp));
  // R10
  idle_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> $stable(sp));
  // R3
  postinc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en && mode == M_POST |-> wb_val == mem_addr + 16'd1);
  // R4
  predec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en && mode == M_PRE |-> wb_val == mem_addr);
  // R1
  wb_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> mem_valid && !mem_wide);
endmodule

// File: tb/ptr_agen_tb.sv
module ptr_agen_tb;
  localparam int PERIOD = 10;

  logic clk = 0, rst_n = 0, req = 0, store = 0;
  logic [1:0] ptr_sel = 0;
  logic [2:0] mode = 0;
  logic [5:0] disp = 0;
  logic [15:0] ptr_x, ptr_y, ptr_z, mem_addr, wb_val, sp;
  logic mem_valid, mem_write, mem_wide, wb_en, stack_fault;
  logic [4:0] wb_idx;
  logic [7:0] rf [32];
  int checks = 0, fails = 0;

  always #(PERIOD/2) clk = ~clk;

  assign ptr_x = {rf[27], rf[26]};
  assign ptr_y = {rf[29], rf[28]};
  assign ptr_z = {rf[31], rf[30]};

  always @(posedge clk)
    if (wb_en) begin
      rf[wb_idx]     <= wb_val[7:0];
      rf[wb_idx + 1] <= wb_val[15:8];
    end

  ptr_agen u_dut (.clk, .rst_n, .req, .ptr_sel, .mode, .disp, .store,
    .ptr_x, .ptr_y, .ptr_z, .mem_valid, .mem_write, .mem_wide, .mem_addr,
    .wb_en, .wb_idx, .wb_val, .sp, .stack_fault);

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic r, input logic [1:0] s, input logic [2:0] m,
                       input logic [5:0] d, input logic st);
    @(negedge clk);
    req = r; ptr_sel = s; mode = m; disp = d; store = st;
    #1;
  endtask

  // {sel, mode, disp, store, addr, wb_en, wb_val}
  localparam logic [44:0] VEC [10] = '{
    {2'd0, 3'd0, 6'd0,  1'b0, 16'h0100, 1'b0, 16'h0000},
    {2'd0, 3'd1, 6'd0,  1'b1, 16'h0100, 1'b1, 16'h0101},
    {2'd0, 3'd1, 6'd0,  1'b0, 16'h0101, 1'b1, 16'h0102},
    {2'd1, 3'd2, 6'd0,  1'b1, 16'h01FF, 1'b1, 16'h01FF},
    {2'd1, 3'd3, 6'd63, 1'b0, 16'h023E, 1'b0, 16'h0000},
    {2'd2, 3'd1, 6'd0,  1'b0, 16'hFFFF, 1'b1, 16'h0000},
    {2'd2, 3'd2, 6'd0,  1'b1, 16'hFFFF, 1'b1, 16'hFFFF},
    {2'd2, 3'd3, 6'd1,  1'b0, 16'h0000, 1'b0, 16'h0000},
    {2'd0, 3'd2, 6'd0,  1'b0, 16'h0101, 1'b1, 16'h0101},
    {2'd1, 3'd0, 6'd0,  1'b1, 16'h01FF, 1'b0, 16'h0000}
  };

  initial begin
    #(PERIOD * 100000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) rf[i] = 8'h00;
    rf[26] = 8'h00; rf[27] = 8'h01;
    rf[28] = 8'h00; rf[29] = 8'h02;
    rf[30] = 8'hFF; rf[31] = 8'hFF;
    #(PERIOD * 3);
    @(negedge clk) rst_n = 1;
    #1;
    // R11 reset state
    chk(sp == 16'h045F, "R11 sp after reset", sp, 16'h045F);
    chk(!mem_valid, "R11 no access while idle", mem_valid, 0);

    for (int i = 0; i < 10; i++) begin
      drive(1, VEC[i][44:43], VEC[i][42:40], VEC[i][39:34], VEC[i][33]);
      // R2 R3 R4 R5 address per mode
      chk(mem_valid && mem_addr == VEC[i][32:17], "R2-R5 vector address", mem_addr, VEC[i][32:17]);
      chk(wb_en == VEC[i][16], "R2 R3 R4 R5 vector wb_en", wb_en, VEC[i][16]);
      if (VEC[i][16]) begin
        chk(wb_val == VEC[i][15:0], "R3 R4 vector write-back", wb_val, VEC[i][15:0]);
        // R1 pair index
        chk(wb_idx == 5'(26 + 2 * VEC[i][44:43]), "R1 write-back index", wb_idx, 26 + 2 * VEC[i][44:43]);
      end
      // R12 direction
      chk(mem_write == VEC[i][33], "R12 store follows input", mem_write, VEC[i][33]);
    end

    // R10 unused select: no access, no write-back, pointers untouched
    drive(1, 2'd3, 3'd1, 6'd0, 1'b1);
    chk(!mem_valid && !wb_en, "R10 select 3 ignored", {mem_valid, wb_en}, 0);
    drive(1, 2'd0, 3'd0, 6'd0, 1'b0);
    chk(mem_addr == 16'h0101, "R10 X unchanged after select 3", mem_addr, 16'h0101);
    drive(1, 2'd2, 3'd0, 6'd0, 1'b0);
    chk(mem_addr == 16'hFFFF, "R10 Z unchanged after select 3", mem_addr, 16'hFFFF);

    // R6 byte push
    drive(1, 2'd0, 3'd4, 6'd0, 1'b0);
    chk(mem_valid && mem_write && !mem_wide && mem_addr == 16'h045F, "R6 push address", mem_addr, 16'h045F);
    // R8 return push
    drive(1, 2'd0, 3'd6, 6'd0, 1'b0);
    chk(sp == 16'h045E, "R6 sp after push", sp, 16'h045E);
    chk(mem_wide && mem_write && mem_addr == 16'h045D, "R8 return push address", mem_addr, 16'h045D);
    drive(1, 2'd0, 3'd7, 6'd0, 1'b0);
    chk(sp == 16'h045C, "R8 sp after return push", sp, 16'h045C);
    chk(mem_wide && !mem_write && mem_addr == 16'h045D, "R8 return pop address", mem_addr, 16'h045D);
    // R7 byte pop
    drive(1, 2'd0, 3'd5, 6'd0, 1'b0);
    chk(sp == 16'h045E, "R8 sp after return pop", sp, 16'h045E);
    chk(mem_valid && !mem_write && mem_addr == 16'h045F, "R7 pop address", mem_addr, 16'h045F);
    drive(0, 2'd0, 3'd4, 6'd0, 1'b0);
    chk(sp == 16'h045F, "R7 sp after pop", sp, 16'h045F);
    drive(0, 2'd0, 3'd4, 6'd0, 1'b0);
    chk(sp == 16'h045F, "R10 idle keeps sp", sp, 16'h045F);

    // R9 drive to the floor
    for (int i = 0; i < 1023; i++) drive(1, 2'd0, 3'd4, 6'd0, 1'b0);
    drive(1, 2'd0, 3'd4, 6'd0, 1'b0);
    chk(sp == 16'h0060, "R9 sp at floor", sp, 16'h0060);
    chk(stack_fault && !mem_valid, "R9 push below floor refused", {stack_fault, mem_valid}, 2'b10);
    drive(1, 2'd0, 3'd5, 6'd0, 1'b0);
    chk(sp == 16'h0060, "R9 sp held on fault", sp, 16'h0060);
    chk(!stack_fault && mem_valid, "R9 pop at floor allowed", stack_fault, 0);
    drive(1, 2'd0, 3'd6, 6'd0, 1'b0);
    chk(sp == 16'h0061, "R7 sp after pop at floor", sp, 16'h0061);
    chk(stack_fault && !mem_valid, "R9 return push below floor refused", stack_fault, 1);
    drive(1, 2'd0, 3'd4, 6'd0, 1'b0);
    chk(!stack_fault && mem_addr == 16'h0061, "R9 push to floor allowed", mem_addr, 16'h0061);
    drive(0, 2'd0, 3'd0, 6'd0, 1'b0);
    chk(sp == 16'h0060, "R6 sp reaches floor", sp, 16'h0060);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule